// File: doc/BRIEF.md
# Background Memory-Scan CRC Engine

This block computes a CRC over a range of program memory while the processor is halted. Software loads a running pointer and an end pointer, each split into a segment and an offset. It seeds the result register, sets the automatic-enable bit and writes the arming code into the mode register. From then on the engine reads one byte per memory word and folds it into the CRC, but only during cycles in which the halt-state input is high. If the halt ends part-way through a range, the engine stops at once and keeps its pointer and partial result. When the halt returns, it carries on from that pointer.

The run finishes when the running pointer equals the end pointer. The end location itself is never read. On completion the engine clears the mode register, raises a sticky interrupt flag and, if the interrupt is enabled, sends a one-cycle wake request to leave the halt state. While an automatic run is unfinished, software can use the same result register for a manual calculation. It clears the automatic-enable bit and feeds bytes through a valid/ready input. It must restore the saved partial result and set the enable bit again before the next halt.

Memory reads use a request/response handshake. `mem_req_o` together with the pointer outputs forms the request. The engine holds the address steady until `mem_rvalid_i` arrives in a cycle in which the request is still high. The memory may take any number of cycles and so applies back-pressure simply by withholding `mem_rvalid_i`. A response in a cycle without a request is discarded. Manual bytes are taken in a cycle where both `man_valid_i` and `man_ready_o` are high. `man_ready_o` is low while automatic mode is enabled, so bytes offered then are never consumed.

Top module: `bgcrc_scan`

## Requirements
- R1: Memory requests are issued only when the mode register holds 0x01, the automatic-enable bit is 1 and `halt_i` is high.
- R2: When `halt_i` falls, `mem_req_o` drops in the same cycle, and the pointer and result hold their values for as long as the halt stays low.
- R3: After a resume, reading continues from the held pointer. The final result equals that of an uninterrupted run over the same range.
- R4: Each accepted word (`mem_req_o` and `mem_rvalid_i` high in the same cycle) advances the pointer {segment, offset} by one. Offset overflow carries into the segment, and the top address wraps to zero.
- R5: When the pointer equals the end pointer during an active cycle, the mode register becomes 0x00 at the next edge and no further reads are made.
- R6: On completion `irq_o` is set and stays set. `wake_o` pulses high for exactly one cycle, at the same edge, and only if `irq_en_i` is high.
- R7: The CRC is 16 bits wide with polynomial 0x1021, non-reflected, with no final inversion. Each byte is processed MSB first in one cycle. The reset value is 0xFFFF, and a software write loads `res_wdata_i`.
- R8: With the automatic-enable bit at 0, `man_ready_o` is high and each accepted manual byte is folded into the result. With the bit at 1, manual bytes leave the result unchanged.
- R9: The pointer changes only through an accepted word or a software write. It therefore keeps the last address reached while automatic mode is disabled.
- R10: If the pointer already equals the end pointer when the engine becomes active, the run completes with no memory request.
- R11: `irq_clr_i` clears `irq_o`. If completion occurs in the same cycle, the set wins.
- R12: A mode value other than 0x01 keeps the engine idle, even while `halt_i` is high.
- R13: While a request is waiting, the address stays stable. A `mem_rvalid_i` without a request changes neither the pointer nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| halt_i | input | 1 | Processor is in the halt state |
| mode_we_i | input | 1 | Write strobe for the mode register |
| mode_wdata_i | input | 8 | Mode value (0x01 arms automatic run) |
| aen_we_i | input | 1 | Write strobe for the automatic-enable bit |
| aen_wdata_i | input | 1 | Automatic-enable value |
| start_we_i | input | 1 | Load the running pointer |
| start_seg_i | input | SEG_W | Running pointer segment to load |
| start_off_i | input | OFF_W | Running pointer offset to load |
| end_we_i | input | 1 | Load the end pointer |
| end_seg_i | input | SEG_W | End pointer segment |
| end_off_i | input | OFF_W | End pointer offset |
| res_we_i | input | 1 | Load the result register |
| res_wdata_i | input | 16 | Result value to load (seed or restore) |
| man_valid_i | input | 1 | Manual byte offered |
| man_byte_i | input | 8 | Manual byte |
| man_ready_o | output | 1 | Manual byte accepted this cycle when valid |
| irq_en_i | input | 1 | Completion interrupt enabled (gates wake) |
| irq_clr_i | input | 1 | Write-one-to-clear for the completion flag |
| mem_req_o | output | 1 | Read request for the word at the pointer |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 8 | Read data |
| ptr_seg_o | output | SEG_W | Running pointer segment (also the read address) |
| ptr_off_o | output | OFF_W | Running pointer offset (also the read address) |
| mode_o | output | 8 | Mode register |
| aen_o | output | 1 | Automatic-enable bit |
| res_o | output | 16 | Result register |
| irq_o | output | 1 | Sticky completion flag |
| wake_o | output | 1 | One-cycle wake request |

## Verification
`mem_req_o` follows `halt_i` in the same cycle. The bench therefore looks at it a moment after changing the halt input. An accepted word changes the pointer and result at that edge. The completion effects (mode 0x00, `irq_o`, `wake_o`) appear one edge after the pointer reaches the end. The bench drives and samples on falling edges. It waits for `irq_o` and then two further falling edges before checking the result, pointer and mode. Wake pulses and request cycles are counted by a monitor that samples just after each rising edge, which gives the exact pulse count and the proof that no read was made.

// File: rtl/bgcrc_pkg.sv
package bgcrc_pkg;
  localparam int MODE_W = 8;
  localparam logic [MODE_W-1:0] MODE_IDLE = 8'h00;
  localparam logic [MODE_W-1:0] MODE_AUTO = 8'h01;
endpackage

// File: rtl/bgcrc_ptr.sv
module bgcrc_ptr #(
  parameter int SEG_W = 4,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_we_i,
  input  logic [SEG_W-1:0] start_seg_i,
  input  logic [OFF_W-1:0] start_off_i,
  input  logic             end_we_i,
  input  logic [SEG_W-1:0] end_seg_i,
  input  logic [OFF_W-1:0] end_off_i,
  input  logic             adv_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [OFF_W-1:0] off_o,
  output logic             at_end_o
);
  localparam int ADDR_W = SEG_W + OFF_W;

  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] end_q;

  // segment and offset kept as one counter so the offset carry ripples into the segment
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (start_we_i) begin
      cur_q <= {start_seg_i, start_off_i};
    end else if (adv_i) begin
      cur_q <= cur_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q <= '0;
    end else if (end_we_i) begin
      end_q <= {end_seg_i, end_off_i};
    end
  end

  assign seg_o    = cur_q[ADDR_W-1:OFF_W];
  assign off_o    = cur_q[OFF_W-1:0];
  assign at_end_o = (cur_q == end_q);

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && !start_we_i |=> {seg_o, off_o} == $past({seg_o, off_o}) + ADDR_W'(1));

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i && !start_we_i |=> $stable({seg_o, off_o}));
endmodule

// File: rtl/bgcrc_crc.sv
module bgcrc_crc #(
  parameter int                 CRC_W  = 16,
  parameter int                 BYTE_W = 8,
  parameter logic [CRC_W-1:0]   POLY   = 16'h1021,
  parameter logic [CRC_W-1:0]   INIT   = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CRC_W-1:0]  load_val_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] folded;

  // one shift stage per data bit, most significant bit first
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    logic [CRC_W-1:0] prev;
    logic [CRC_W-1:0] nxt;
    logic             fb;
    if (i == 0) begin : g_first
      assign prev = crc_q;
    end else begin : g_rest
      assign prev = g_bit[i-1].nxt;
    end
    assign fb  = prev[CRC_W-1] ^ byte_i[BYTE_W-1-i];
    assign nxt = {prev[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign folded = g_bit[BYTE_W-1].nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= INIT;
    end else if (load_i) begin
      crc_q <= load_val_i;
    end else if (upd_i) begin
      crc_q <= folded;
    end
  end

  assign crc_o = crc_q;

  // R2
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i && !upd_i |=> $stable(crc_o));

  // R7
  crc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> crc_o == $past(load_val_i));
endmodule

// File: rtl/bgcrc_ctrl.sv
module bgcrc_ctrl
  import bgcrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              aen_we_i,
  input  logic              aen_wdata_i,
  input  logic              irq_en_i,
  input  logic              irq_clr_i,
  input  logic              at_end_i,
  input  logic              mem_rvalid_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              aen_o,
  output logic              mem_req_o,
  output logic              accept_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [MODE_W-1:0] mode_q;
  logic              aen_q;
  logic              irq_q;
  logic              wake_q;
  logic              run;
  logic              done;

  assign run       = (mode_q == MODE_AUTO) && aen_q && halt_i;
  assign done      = run && at_end_i;
  assign mem_req_o = run && !at_end_i;
  assign accept_o  = mem_req_o && mem_rvalid_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
    end else if (mode_we_i) begin
      mode_q <= mode_wdata_i;
    end else if (done) begin
      mode_q <= MODE_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aen_q <= 1'b0;
    end else if (aen_we_i) begin
      aen_q <= aen_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= done && irq_en_i;
      if (done) begin
        irq_q <= 1'b1;
      end else if (irq_clr_i) begin
        irq_q <= 1'b0;
      end
    end
  end

  assign mode_o = mode_q;
  assign aen_o  = aen_q;
  assign irq_o  = irq_q;
  assign wake_o = wake_q;

  // R1
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> halt_i && aen_o && (mode_o == MODE_AUTO));

  // R5
  done_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !mode_we_i |=> mode_o == MODE_IDLE);

  // R6
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  // R6
  wake_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> irq_o);

  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !irq_clr_i |=> irq_o);
endmodule

// File: rtl/bgcrc_scan.sv
module bgcrc_scan
  import bgcrc_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              aen_we_i,
  input  logic              aen_wdata_i,
  input  logic              start_we_i,
  input  logic [SEG_W-1:0]  start_seg_i,
  input  logic [OFF_W-1:0]  start_off_i,
  input  logic              end_we_i,
  input  logic [SEG_W-1:0]  end_seg_i,
  input  logic [OFF_W-1:0]  end_off_i,
  input  logic              res_we_i,
  input  logic [15:0]       res_wdata_i,
  input  logic              man_valid_i,
  input  logic [7:0]        man_byte_i,
  output logic              man_ready_o,
  input  logic              irq_en_i,
  input  logic              irq_clr_i,
  output logic              mem_req_o,
  input  logic              mem_rvalid_i,
  input  logic [7:0]        mem_rdata_i,
  output logic [SEG_W-1:0]  ptr_seg_o,
  output logic [OFF_W-1:0]  ptr_off_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              aen_o,
  output logic [15:0]       res_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic       at_end;
  logic       accept;
  logic       man_fire;
  logic       upd;
  logic [7:0] upd_byte;

  bgcrc_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_i       (halt_i),
    .mode_we_i    (mode_we_i),
    .mode_wdata_i (mode_wdata_i),
    .aen_we_i     (aen_we_i),
    .aen_wdata_i  (aen_wdata_i),
    .irq_en_i     (irq_en_i),
    .irq_clr_i    (irq_clr_i),
    .at_end_i     (at_end),
    .mem_rvalid_i (mem_rvalid_i),
    .mode_o       (mode_o),
    .aen_o        (aen_o),
    .mem_req_o    (mem_req_o),
    .accept_o     (accept),
    .irq_o        (irq_o),
    .wake_o       (wake_o)
  );

  bgcrc_ptr #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_we_i  (start_we_i),
    .start_seg_i (start_seg_i),
    .start_off_i (start_off_i),
    .end_we_i    (end_we_i),
    .end_seg_i   (end_seg_i),
    .end_off_i   (end_off_i),
    .adv_i       (accept),
    .seg_o       (ptr_seg_o),
    .off_o       (ptr_off_o),
    .at_end_o    (at_end)
  );

  // manual path is open only while automatic mode is disabled
  assign man_ready_o = !aen_o;
  assign man_fire    = man_valid_i && man_ready_o;
  assign upd         = accept || man_fire;
  assign upd_byte    = accept ? mem_rdata_i : man_byte_i;

  bgcrc_crc #(.CRC_W(16), .BYTE_W(8), .POLY(16'h1021), .INIT(16'hFFFF)) u_crc (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (res_we_i),
    .load_val_i (res_wdata_i),
    .upd_i      (upd),
    .byte_i     (upd_byte),
    .crc_o      (res_o)
  );

  // R13
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_rvalid_i && !start_we_i |=> $stable({ptr_seg_o, ptr_off_o}));

  // R8
  man_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aen_o && man_valid_i && !mem_req_o && !res_we_i |=> $stable(res_o));
endmodule

// File: tb/bgcrc_scan_tb.sv
`timescale 1ns/1ps
module bgcrc_scan_tb;
  localparam int SEG_W = 2;
  localparam int OFF_W = 3;
  localparam int NLOC  = 1 << (SEG_W + OFF_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             halt = 0, mode_we = 0, aen_we = 0, aen_wd = 0;
  logic [7:0]       mode_wd = 0;
  logic             start_we = 0, end_we = 0, res_we = 0;
  logic [SEG_W-1:0] start_seg = 0, end_seg = 0;
  logic [OFF_W-1:0] start_off = 0, end_off = 0;
  logic [15:0]      res_wd = 0;
  logic             man_valid = 0, irq_en = 0, irq_clr = 0;
  logic [7:0]       man_byte = 0;
  logic             man_ready, mem_req, irq, wake, aen;
  logic             mdl_rvalid = 0, spur = 0;
  logic [7:0]       mem_rdata = 0;
  logic [SEG_W-1:0] pseg;
  logic [OFF_W-1:0] poff;
  logic [7:0]       mode;
  logic [15:0]      res;

  int n_chk = 0, n_err = 0, wake_cnt = 0, req_cnt = 0, salt = 0;

  bgcrc_scan #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .halt_i(halt),
    .mode_we_i(mode_we), .mode_wdata_i(mode_wd),
    .aen_we_i(aen_we), .aen_wdata_i(aen_wd),
    .start_we_i(start_we), .start_seg_i(start_seg), .start_off_i(start_off),
    .end_we_i(end_we), .end_seg_i(end_seg), .end_off_i(end_off),
    .res_we_i(res_we), .res_wdata_i(res_wd),
    .man_valid_i(man_valid), .man_byte_i(man_byte), .man_ready_o(man_ready),
    .irq_en_i(irq_en), .irq_clr_i(irq_clr),
    .mem_req_o(mem_req), .mem_rvalid_i(mdl_rvalid | spur), .mem_rdata_i(mem_rdata),
    .ptr_seg_o(pseg), .ptr_off_o(poff), .mode_o(mode), .aen_o(aen),
    .res_o(res), .irq_o(irq), .wake_o(wake)
  );

  function automatic logic [7:0] mem_byte(input int a);
    return 8'((a * 29 + 7) ^ (a >> 2));
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[15] ^ b[i];
      r = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  function automatic logic [15:0] crc_range(input logic [15:0] seed, input int s, input int len);
    logic [15:0] c = seed;
    for (int i = 0; i < len; i++) c = crc_step(c, mem_byte((s + i) % NLOC));
    return c;
  endfunction

  // memory model: variable wait, one response per request
  int mcnt = 0;
  always @(negedge clk) begin
    if (mdl_rvalid) begin
      mdl_rvalid <= 1'b0;
      mcnt <= 0;
    end else if (mem_req) begin
      if (mcnt >= (({pseg, poff} + salt) % 4)) begin
        mdl_rvalid <= 1'b1;
        mem_rdata  <= mem_byte({pseg, poff});
      end else begin
        mcnt <= mcnt + 1;
      end
    end else begin
      mcnt <= 0;
    end
  end

  always @(posedge clk) begin
    #1;
    if (wake) wake_cnt++;
    if (mem_req) req_cnt++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int ptr_lin();
    return int'({pseg, poff});
  endfunction

  task automatic arm(input int s, input int e, input logic [15:0] seed,
                     input logic [7:0] m, input logic ien);
    @(negedge clk);
    start_we = 1; {start_seg, start_off} = (SEG_W + OFF_W)'(s);
    end_we = 1;   {end_seg, end_off} = (SEG_W + OFF_W)'(e);
    res_we = 1; res_wd = seed;
    aen_we = 1; aen_wd = 1;
    mode_we = 1; mode_wd = m;
    irq_clr = 1; irq_en = ien;
    @(negedge clk);
    start_we = 0; end_we = 0; res_we = 0; aen_we = 0; mode_we = 0; irq_clr = 0;
    wake_cnt = 0; req_cnt = 0;
  endtask

  task automatic wait_irq(input string tag);
    for (int i = 0; i < 600 && !irq; i++) @(negedge clk);
    check({tag, " completion timeout"}, 32'(irq), 32'd1);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lens[4] = '{0, 1, 8, 13};
    logic [15:0] r0, man_exp;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    check("R7 reset result", 32'(res), 32'hFFFF);
    check("R5 reset mode", 32'(mode), 32'h0);
    check("R6 reset irq/wake", {30'd0, irq, wake}, 32'd0);
    check("R9 reset pointer", ptr_lin(), 32'd0);
    check("R1 reset request", 32'(mem_req), 32'd0);

    // R1: armed but no halt -> no request
    arm(4, 12, 16'hFFFF, 8'h01, 1'b1);
    repeat (10) @(negedge clk);
    check("R1 no request without halt", req_cnt, 0);
    check("R1 pointer idle without halt", ptr_lin(), 4);

    // R12: other mode code stays idle
    arm(4, 12, 16'hFFFF, 8'h02, 1'b1);
    halt = 1;
    repeat (12) @(negedge clk);
    halt = 0;
    check("R12 no request for mode 0x02", req_cnt, 0);
    check("R12 no completion for mode 0x02", 32'(irq), 32'd0);

    // sweep over every start and several lengths (R4 carry/wrap, R5..R7, R10)
    for (int s = 0; s < NLOC; s++) begin
      for (int li = 0; li < 4; li++) begin
        int len = lens[li];
        logic ien = 1'((s + li) % 2);
        salt = s + li;
        arm(s, (s + len) % NLOC, 16'hFFFF, 8'h01, ien);
        halt = 1;
        wait_irq("R5 sweep");
        halt = 0;
        @(negedge clk); @(negedge clk);
        check($sformatf("R7 crc s=%0d len=%0d", s, len), 32'(res), 32'(crc_range(16'hFFFF, s, len)));
        check($sformatf("R4 pointer s=%0d len=%0d", s, len), ptr_lin(), (s + len) % NLOC);
        check("R5 mode cleared", 32'(mode), 32'h0);
        check("R6 irq sticky", 32'(irq), 32'd1);
        check("R6 wake pulses", wake_cnt, 32'(ien));
        if (len == 0) check("R10 empty range reads nothing", req_cnt, 0);
      end
    end

    // R11 clear
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    check("R11 irq cleared", 32'(irq), 32'd0);

    // R13 stray response without request
    p0 = ptr_lin(); r0 = res;
    spur = 1; @(negedge clk); spur = 0; @(negedge clk);
    check("R13 stray valid pointer", ptr_lin(), p0);
    check("R13 stray valid result", 32'(res), 32'(r0));

    // R8 manual bytes blocked while automatic enabled
    man_valid = 1; man_byte = 8'h5A; @(negedge clk); man_valid = 0;
    check("R8 manual ignored while enabled", 32'(res), 32'(r0));

    // abort / manual / resume
    salt = 1;
    arm(3, 23, 16'hFFFF, 8'h01, 1'b1);
    halt = 1;
    repeat (20) @(negedge clk);
    halt = 0;
    #1;
    check("R2 request drops with halt", 32'(mem_req), 32'd0);
    @(negedge clk);
    p0 = ptr_lin(); r0 = res;
    repeat (8) @(negedge clk);
    check("R2 pointer held", ptr_lin(), p0);
    check("R2 result held", 32'(res), 32'(r0));
    check("R3 partial progress", 32'(p0 != 3 && p0 != 23), 32'd1);
    check("R2 partial crc", 32'(r0), 32'(crc_range(16'hFFFF, 3, (p0 - 3 + NLOC) % NLOC)));
    aen_we = 1; aen_wd = 0; res_we = 1; res_wd = 16'hFFFF;
    @(negedge clk);
    aen_we = 0; res_we = 0;
    halt = 1; req_cnt = 0;
    man_exp = 16'hFFFF;
    for (int k = 0; k < 4; k++) begin
      man_valid = 1; man_byte = 8'(8'h31 + k * 17);
      man_exp = crc_step(man_exp, man_byte);
      check("R8 ready while disabled", 32'(man_ready), 32'd1);
      @(negedge clk);
    end
    man_valid = 0;
    check("R8 manual crc", 32'(res), 32'(man_exp));
    check("R1 no request while disabled", req_cnt, 0);
    check("R9 pointer kept while disabled", ptr_lin(), p0);
    halt = 0;
    res_we = 1; res_wd = r0; aen_we = 1; aen_wd = 1;
    @(negedge clk);
    res_we = 0; aen_we = 0;
    halt = 1;
    wait_irq("R3 resume");
    halt = 0;
    @(negedge clk); @(negedge clk);
    check("R3 resumed crc", 32'(res), 32'(crc_range(16'hFFFF, 3, 20)));
    check("R3 resumed pointer", ptr_lin(), 23);
    check("R6 wake after resume", wake_cnt, 1);
    repeat (5) @(negedge clk);
    check("R11 irq stays set", 32'(irq), 32'd1);

    finish_run();
  end
endmodule